// File: doc/BRIEF.md
# SIMD Floating-Point Exception Control Unit

This block sits beside a SIMD execution unit and turns the floating-point exception conditions that unit reports into architectural state and trap requests. When an instruction completes, the execution unit presents a six-bit condition vector together with an indication of whether the operation was floating-point or packed integer. For floating-point work, each raised condition sets a sticky status flag in a control/status register. If any raised condition has its mask bit clear, a trap is requested in that same completion cycle. Packed integer completions never raise numeric exceptions, so their condition bits are discarded.

The trap type depends on an operating-system support enable bit. When the bit is set, the trap is a SIMD floating-point exception. When it is clear, an unmasked condition instead produces an undefined-operation trap. Software loads the whole register through a write port and reads flags and masks back through a read port. The completion report is a plain per-cycle strobe with no back-pressure: the block accepts a report in every cycle and never stalls the execution unit. The register ports are also plain, and each write takes effect at the next clock edge.

Top module: `fpx_except_ctrl`

## Requirements
- R1: The condition vector and the flag field share one bit order: bit 0 invalid operation, bit 1 denormal operand, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow, bit 5 inexact result.
- R2: The register value holds the flags in bits 0..5 and the masks in bits 7..12, each field in the R1 order. Every other bit reads as zero.
- R3: Flags are sticky. Once set, a flag stays set until a register write loads a new value into it.
- R4: A completion marked packed integer leaves the flags unchanged and never requests a trap, whatever its condition bits.
- R5: A floating-point completion sets the flag of every raised condition at the next clock edge, whether that condition is masked or not.
- R6: `trap_req` is high only in a cycle that carries a floating-point completion. It is a single-cycle signal, with one request per completion however many conditions are unmasked.
- R7: When a raised condition is unmasked and `os_simd_en` is 1, `trap_req` is 1 and `trap_kind` is 0 (SIMD floating-point trap).
- R8: When a raised condition is unmasked and `os_simd_en` is 0, `trap_req` is 1 and `trap_kind` is 1 (undefined-operation trap).
- R9: A completion whose raised conditions are all masked requests no trap. `trap_kind` reads 0 whenever `trap_req` is 0.
- R10: After reset all flags are 0 and all six masks are 1, so the register reads 0x1F80.
- R11: If a write and a completion arrive in the same cycle, the trap decision uses the masks held before the write. The new flags are the written flags OR the raised conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_is_fp | input | 1 | 1 = floating-point operation, 0 = packed integer |
| cmp_cond | input | 6 | Raised conditions, in R1 order |
| os_simd_en | input | 1 | Operating-system support for SIMD floating-point traps |
| csr_wr_en | input | 1 | Load the register from `csr_wr_data` |
| csr_wr_data | input | 32 | New register value, in R2 layout |
| csr_rd_data | output | 32 | Current register value |
| trap_req | output | 1 | Trap request for the completing instruction |
| trap_kind | output | 1 | 0 = SIMD floating-point trap, 1 = undefined-operation trap |

## Verification
The bench builds the block with its default parameters: six conditions, a 32-bit register and the masks starting at bit 7. At this size every mask pattern can be crossed with every condition pattern, both operation types and both settings of the OS-support bit, which covers all 16384 combinations in a single run. Expected trap and flag values are worked out bit by bit in the bench. Directed sequences then cover sticky accumulation across completions, the reset value, and a write and a completion landing in the same cycle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int unsigned FPX_NCOND    = 6;
  localparam int unsigned FPX_CSR_W    = 32;
  localparam int unsigned FPX_MASK_LSB = 7;

  typedef enum logic {
    TRAP_SIMD_FP  = 1'b0,
    TRAP_UNDEF_OP = 1'b1
  } fpx_trap_kind_e;

endpackage

// File: rtl/fpx_status_reg.sv
module fpx_status_reg #(
  parameter int unsigned NCOND    = fpx_pkg::FPX_NCOND,
  parameter int unsigned CSR_W    = fpx_pkg::FPX_CSR_W,
  parameter int unsigned MASK_LSB = fpx_pkg::FPX_MASK_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             rec_valid,
  input  logic [NCOND-1:0] rec_cond,
  output logic [NCOND-1:0] flags_o,
  output logic [NCOND-1:0] masks_o
);

  for (genvar i = 0; i < NCOND; i++) begin : g_cell
    logic flag_q;
    logic mask_q;
    logic hit;

    assign hit = rec_valid & rec_cond[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        mask_q <= 1'b1;
      end else begin
        if (wr_en) begin
          flag_q <= wr_data[i] | hit;
          mask_q <= wr_data[MASK_LSB + i];
        end else if (hit) begin
          flag_q <= 1'b1;
        end
      end
    end

    assign flags_o[i] = flag_q;
    assign masks_o[i] = mask_q;
  end

  // R3
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R5
  capture_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> ((flags_o & $past(rec_cond)) == $past(rec_cond)));

endmodule

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter #(
  parameter int unsigned NCOND = fpx_pkg::FPX_NCOND
) (
  input  logic                   cmp_valid,
  input  logic                   cmp_is_fp,
  input  logic [NCOND-1:0]       cmp_cond,
  input  logic [NCOND-1:0]       masks,
  input  logic                   os_simd_en,
  output logic                   rec_valid,
  output logic                   trap_req,
  output fpx_pkg::fpx_trap_kind_e trap_kind
);

  logic [NCOND-1:0] unmasked;

  always_comb begin
    rec_valid = cmp_valid & cmp_is_fp;
    unmasked  = cmp_cond & ~masks;
    trap_req  = rec_valid & (|unmasked);
    if (trap_req && !os_simd_en) trap_kind = fpx_pkg::TRAP_UNDEF_OP;
    else                         trap_kind = fpx_pkg::TRAP_SIMD_FP;
  end

endmodule

// File: rtl/fpx_except_ctrl.sv
module fpx_except_ctrl #(
  parameter int unsigned NCOND    = fpx_pkg::FPX_NCOND,
  parameter int unsigned CSR_W    = fpx_pkg::FPX_CSR_W,
  parameter int unsigned MASK_LSB = fpx_pkg::FPX_MASK_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             cmp_is_fp,
  input  logic [NCOND-1:0] cmp_cond,
  input  logic             os_simd_en,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wr_data,
  output logic [CSR_W-1:0] csr_rd_data,
  output logic             trap_req,
  output logic             trap_kind
);

  logic [NCOND-1:0]        flags;
  logic [NCOND-1:0]        masks;
  logic                    rec_valid;
  fpx_pkg::fpx_trap_kind_e kind_e;

  fpx_trap_arbiter #(.NCOND(NCOND)) u_arb (
    .cmp_valid  (cmp_valid),
    .cmp_is_fp  (cmp_is_fp),
    .cmp_cond   (cmp_cond),
    .masks      (masks),
    .os_simd_en (os_simd_en),
    .rec_valid  (rec_valid),
    .trap_req   (trap_req),
    .trap_kind  (kind_e)
  );

  fpx_status_reg #(.NCOND(NCOND), .CSR_W(CSR_W), .MASK_LSB(MASK_LSB)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (csr_wr_en),
    .wr_data   (csr_wr_data),
    .rec_valid (rec_valid),
    .rec_cond  (cmp_cond),
    .flags_o   (flags),
    .masks_o   (masks)
  );

  assign trap_kind = kind_e;

  always_comb begin
    csr_rd_data = '0;
    csr_rd_data[NCOND-1:0]         = flags;
    csr_rd_data[MASK_LSB +: NCOND] = masks;
  end

  // R6
  trap_on_fp_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (cmp_valid && cmp_is_fp));

  // R4
  int_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_is_fp && !csr_wr_en) |=> $stable(csr_rd_data[NCOND-1:0]));

  // R9
  kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_kind == 1'b0));

endmodule

// File: tb/fpx_except_ctrl_test.sv
module fpx_except_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_is_fp = 1'b0;
  logic [5:0]  cmp_cond = '0;
  logic        os_simd_en = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic [31:0] csr_rd_data;
  logic        trap_req;
  logic        trap_kind;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_except_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_is_fp(cmp_is_fp),
    .cmp_cond(cmp_cond), .os_simd_en(os_simd_en), .csr_wr_en(csr_wr_en),
    .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
    .trap_req(trap_req), .trap_kind(trap_kind)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmp_valid = 1'b0; csr_wr_en = 1'b0; cmp_cond = '0;
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk);
    cmp_valid = 1'b0; csr_wr_en = 1'b1; csr_wr_data = v;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic complete(input logic fp, input logic [5:0] c, input logic os);
    cmp_valid = 1'b1; cmp_is_fp = fp; cmp_cond = c; os_simd_en = os;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset value
    check("R10 reset csr", csr_rd_data, 32'h0000_1F80);
    // R9 all masked after reset: no trap
    complete(1'b1, 6'h3F, 1'b1);
    #1;
    check("R9 masked no trap", {31'd0, trap_req}, 32'd0);
    idle();
    #1;
    check("R5 masked still flagged", csr_rd_data, 32'h0000_1FBF);

    // Exhaustive sweep: R1 R2 R4 R5 R6 R7 R8 R9
    for (int m = 0; m < 64; m++) begin
      for (int c = 0; c < 64; c++) begin
        for (int k = 0; k < 4; k++) begin
          logic fp, os, exp_trap, exp_kind;
          logic [31:0] exp_csr;
          fp = k[0]; os = k[1];
          csr_write(32'(m) << 7);
          complete(fp, 6'(c), os);
          exp_trap = fp && ((c & ~m & 6'h3F) != 0);
          exp_kind = exp_trap && !os;
          #1;
          check(os ? "R7 trap_req" : "R8 trap_req", {31'd0, trap_req}, {31'd0, exp_trap});
          check(exp_trap ? (os ? "R7 kind" : "R8 kind") : "R9 kind idle",
                {31'd0, trap_kind}, {31'd0, exp_kind});
          @(negedge clk);
          cmp_valid = 1'b0;
          exp_csr = (32'(m) << 7) | (fp ? 32'(c) : 32'd0);
          #1;
          check(fp ? "R5 R1 R2 flags" : "R4 integer ignored", csr_rd_data, exp_csr);
          check("R6 single pulse", {31'd0, trap_req}, 32'd0);
        end
      end
    end

    // R3 sticky accumulation
    csr_write(32'h0000_1F80);
    complete(1'b1, 6'h01, 1'b1);
    @(negedge clk); complete(1'b1, 6'h04, 1'b1);
    @(negedge clk); complete(1'b0, 6'h3A, 1'b1);
    @(negedge clk); complete(1'b1, 6'h00, 1'b1);
    idle();
    #1;
    check("R3 sticky", csr_rd_data, 32'h0000_1F85);
    csr_write(32'h0000_1F80);
    #1;
    check("R3 write clears", csr_rd_data, 32'h0000_1F80);

    // R11 write and completion together: old masks decide
    csr_write(32'h0000_0000);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_data = 32'h0000_1F82;
    complete(1'b1, 6'h10, 1'b1);
    #1;
    check("R11 old masks trap", {31'd0, trap_req}, 32'd1);
    idle();
    #1;
    check("R11 merged flags", csr_rd_data, 32'h0000_1F92);
    check("R2 reserved zero", csr_rd_data & 32'hFFFF_E040, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule